// File: doc/BRIEF.md
# Triggered Result Integration Window

This block sums filter results over windows opened by a trigger. A result stream (data with a valid strobe) and a small vector of trigger lines come in. A select input picks one trigger line. That line passes through a two-flop synchronizer and an edge detector. The chosen start edge opens a window. In each window a programmed number of leading results is thrown away. The block then adds up a programmed number of results and delivers each total as one integrated result with a single-clock valid pulse.

A window runs one of two ways:
- **Counted:** it runs for a programmed number of summing cycles.
- **Edge-ended:** it runs until the opposite trigger edge.

Two further mode codes change the behaviour:
- **Pass-through:** the integrator is skipped and results go straight to the output.
- **Permanent:** the window is held open for good.

A status flag shows whether a window is open. Two live counters show progress: results summed in the current cycle, and completed cycles.

Top module: `trig_window_integrator`

## Requirements
- R1: While reset is held and after it is released, `intValid`, `intData`, `intEnable`, `valCount` and `cycCount` are all zero until a result or trigger event changes them.
- R2: With `trigMode` = 2'b00 (pass-through), every result with `resValid` high appears on `intData`, sign-extended, one clock later with `intValid` high. In this mode `intEnable`, `valCount` and `cycCount` stay zero.
- R3: With `trigMode` = 2'b10 the window opens on a rising edge of the selected trigger; with 2'b01 it opens on a falling edge. The trigger is synchronized by two flops and compared with a third, so `intEnable` rises at the third rising clock edge after the line changes. Opening the window clears `valCount` and `cycCount`.
- R4: Once a window opens, the first `discardNum` results (0 to 31) are dropped and do not affect the sum or the counters.
- R5: After the discard phase, `integNum`+1 results (1 to 32) are summed. `valCount` shows how many have been summed so far in the current cycle. The result that completes the cycle makes `intValid` high for exactly one clock, one clock later, with the exact signed sum. `valCount` then returns to zero.
- R6: With `extWindow` = 0, each completed sum increments `cycCount` (3 bits, wrapping). After `repeatNum`+1 sums, `intEnable` clears at the same clock edge that registers the last sum.
- R7: With `extWindow` = 1 and an edge-started mode, the window stays open through any number of cycles. It closes on the trigger edge opposite to the start edge. A partial sum in progress at that point is dropped with no output, and `valCount` returns to zero.
- R8: With `trigMode` = 2'b11 (permanent), `intEnable` is high from the clock after the mode is applied. The discard phase runs once when the window opens. Sums repeat with no end, trigger edges are ignored, and `cycCount` stays zero.
- R9: Only the trigger line indexed by `trigSel` is used; edges on the other lines have no effect.
- R10: While a window is open, further start edges have no effect. With `extWindow` = 0, opposite edges have no effect either.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigVec | input | TRIGS | Asynchronous trigger lines |
| trigSel | input | SELW | Index of the trigger line in use |
| trigMode | input | 2 | 00 pass-through, 01 falling start, 10 rising start, 11 permanent |
| extWindow | input | 1 | 1: opposite edge ends the window; 0: cycle count ends it |
| discardNum | input | 5 | Results dropped after the window opens |
| integNum | input | 5 | Results per sum, minus one |
| repeatNum | input | 3 | Summing cycles per counted window, minus one |
| resValid | input | 1 | Result strobe |
| resData | input | DW | Signed result |
| intValid | output | 1 | Integrated result strobe |
| intData | output | DW+5 | Signed integrated result |
| intEnable | output | 1 | Window open flag |
| valCount | output | 5 | Results summed in the current cycle |
| cycCount | output | 3 | Completed summing cycles in the window |

## Verification
A wrong internal state in this block becomes visible at the ports within a few clocks.
- A bad discard count or summing count shifts which results go into a total. The first integrated value then differs from the reference, or its valid pulse arrives on the wrong clock, by the end of the first cycle.
- A broken edge detector or synchronizer opens the window at the wrong clock, or not at all. This shows on `intEnable` within three clocks of the trigger change.
- Errors in the closing logic leave `intEnable` high, or drop it early, at the edge where the last sum or the opposite edge arrives.
- The live counters are compared every clock, so any drift in them is reported on the clock where it first appears.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int CNTW = 5;
  localparam int CYCW = 3;

  typedef enum logic [1:0] {
    TM_BYPASS = 2'b00,
    TM_FALL   = 2'b01,
    TM_RISE   = 2'b10,
    TM_ALWAYS = 2'b11
  } trig_mode_e;

  typedef struct packed {
    logic first;   // sample starts a new sum
    logic accum;   // sample enters the sum
    logic emit;    // sample completes the sum
    logic bypass;  // sample passes straight through
  } twi_strobe_t;
endpackage

// File: rtl/twi_ctrl.sv
module twi_ctrl
  import twi_pkg::*;
#(
  parameter int TRIGS = 4,
  localparam int SELW = (TRIGS > 1) ? $clog2(TRIGS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TRIGS-1:0] trigVec,
  input  logic [SELW-1:0]  trigSel,
  input  trig_mode_e       mode,
  input  logic             extWindow,
  input  logic [CNTW-1:0]  discardNum,
  input  logic [CNTW-1:0]  integNum,
  input  logic [CYCW-1:0]  repeatNum,
  input  logic             resValid,
  output twi_strobe_t      stb,
  output logic             enable,
  output logic [CNTW-1:0]  valCount,
  output logic [CYCW-1:0]  cycCount
);
  logic [1:0]      syncQ;
  logic            trigPrev;
  logic [CNTW-1:0] discLeft;
  logic            rise, fall, startEv, stopEv, permanent;
  logic            closeExt, take, summing, lastVal, stopInt;

  always_comb begin
    rise      = syncQ[1] & ~trigPrev;
    fall      = ~syncQ[1] & trigPrev;
    startEv   = ((mode == TM_RISE) & rise) | ((mode == TM_FALL) & fall);
    stopEv    = ((mode == TM_RISE) & fall) | ((mode == TM_FALL) & rise);
    permanent = (mode == TM_ALWAYS);
    closeExt  = enable & ~permanent & extWindow & stopEv;
    take      = enable & resValid & ~closeExt & (mode != TM_BYPASS);
    summing   = take & (discLeft == '0);
    lastVal   = summing & (valCount == integNum);
    stopInt   = lastVal & ~permanent & ~extWindow & (cycCount == repeatNum);
    stb.bypass = (mode == TM_BYPASS) & resValid;
    stb.first  = summing & (valCount == '0);
    stb.accum  = summing;
    stb.emit   = lastVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ    <= '0;
      trigPrev <= 1'b0;
      enable   <= 1'b0;
      discLeft <= '0;
      valCount <= '0;
      cycCount <= '0;
    end else begin
      syncQ    <= {syncQ[0], trigVec[trigSel]};
      trigPrev <= syncQ[1];
      if (mode == TM_BYPASS) begin
        enable   <= 1'b0;
        discLeft <= '0;
        valCount <= '0;
        cycCount <= '0;
      end else if (!enable) begin
        if (permanent | startEv) begin
          enable   <= 1'b1;
          discLeft <= discardNum;
          valCount <= '0;
          cycCount <= '0;
        end
      end else if (closeExt) begin
        enable   <= 1'b0;
        valCount <= '0;
      end else if (take) begin
        if (discLeft != '0) begin
          discLeft <= CNTW'(discLeft - 1'b1);
        end else if (lastVal) begin
          valCount <= '0;
          if (stopInt) enable <= 1'b0;
          cycCount <= permanent ? '0 : CYCW'(cycCount + 1'b1);
        end else begin
          valCount <= CNTW'(valCount + 1'b1);
        end
      end
    end
  end

  // R3: a start edge on a closed window opens it with cleared counters
  a_r3_start_opens: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && startEv) |=> (enable && valCount == '0 && cycCount == '0));

  // R6: the last counted sum closes the window
  a_r6_internal_stop: assert property (@(posedge clk) disable iff (!rstN)
    (lastVal && !extWindow && (mode == TM_RISE || mode == TM_FALL)
     && cycCount == repeatNum) |=> !enable);

  // R8: permanent mode keeps the window open
  a_r8_always_open: assert property (@(posedge clk) disable iff (!rstN)
    (mode == TM_ALWAYS) |=> enable);

  // R2: pass-through keeps window and counters idle
  a_r2_bypass_idle: assert property (@(posedge clk) disable iff (!rstN)
    (mode == TM_BYPASS) |=> (!enable && valCount == '0 && cycCount == '0));

  // R5: completing a sum restarts the value count
  a_r5_count_restart: assert property (@(posedge clk) disable iff (!rstN)
    stb.emit |=> (valCount == '0));

  // R4: nothing is summed during the discard phase
  a_r4_discard_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (discLeft != '0) |-> !stb.accum);
endmodule

// File: rtl/twi_datapath.sv
module twi_datapath
  import twi_pkg::*;
#(
  parameter int DW = 16,
  localparam int AW = DW + CNTW
) (
  input  logic          clk,
  input  logic          rstN,
  input  twi_strobe_t   stb,
  input  logic [DW-1:0] resData,
  output logic          outValid,
  output logic [AW-1:0] outData
);
  logic [AW-1:0] acc, sampleExt, sum;

  always_comb begin
    sampleExt = {{(AW-DW){resData[DW-1]}}, resData};
    sum       = stb.first ? sampleExt : AW'(acc + sampleExt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc      <= '0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      if (stb.accum) acc <= sum;
      outValid <= stb.emit | stb.bypass;
      if (stb.emit)        outData <= sum;
      else if (stb.bypass) outData <= sampleExt;
    end
  end

  // R2: a passed-through sample keeps its sign
  a_r2_bypass_sign: assert property (@(posedge clk) disable iff (!rstN)
    stb.bypass |=> (outValid && outData[AW-1] == $past(resData[DW-1])));

  // R5: an emitted sum is always flagged valid
  a_r5_emit_valid: assert property (@(posedge clk) disable iff (!rstN)
    stb.emit |=> outValid);
endmodule

// File: rtl/trig_window_integrator.sv
module trig_window_integrator
  import twi_pkg::*;
#(
  parameter int TRIGS = 4,
  parameter int DW    = 16,
  localparam int SELW = (TRIGS > 1) ? $clog2(TRIGS) : 1,
  localparam int AW   = DW + CNTW
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TRIGS-1:0] trigVec,
  input  logic [SELW-1:0]  trigSel,
  input  logic [1:0]       trigMode,
  input  logic             extWindow,
  input  logic [CNTW-1:0]  discardNum,
  input  logic [CNTW-1:0]  integNum,
  input  logic [CYCW-1:0]  repeatNum,
  input  logic             resValid,
  input  logic [DW-1:0]    resData,
  output logic             intValid,
  output logic [AW-1:0]    intData,
  output logic             intEnable,
  output logic [CNTW-1:0]  valCount,
  output logic [CYCW-1:0]  cycCount
);
  twi_strobe_t stb;
  trig_mode_e  mode;

  assign mode = trig_mode_e'(trigMode);

  twi_ctrl #(.TRIGS(TRIGS)) uCtrl (
    .clk(clk), .rstN(rstN), .trigVec(trigVec), .trigSel(trigSel),
    .mode(mode), .extWindow(extWindow), .discardNum(discardNum),
    .integNum(integNum), .repeatNum(repeatNum), .resValid(resValid),
    .stb(stb), .enable(intEnable), .valCount(valCount), .cycCount(cycCount)
  );

  twi_datapath #(.DW(DW)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .resData(resData),
    .outValid(intValid), .outData(intData)
  );
endmodule

// File: tb/trig_window_integrator_test.sv
module trig_window_integrator_test;
  localparam int TRIGS = 4;
  localparam int DW    = 16;
  localparam int AW    = DW + 5;

  logic clk = 0, rstN = 0;
  logic [TRIGS-1:0] trigVec = '0;
  logic [1:0] trigSel = 0, trigMode = 0;
  logic extWindow = 0;
  logic [4:0] discardNum = 0, integNum = 0;
  logic [2:0] repeatNum = 0;
  logic resValid = 0;
  logic [DW-1:0] resData = 0;
  logic intValid, intEnable;
  logic [AW-1:0] intData;
  logic [4:0] valCount;
  logic [2:0] cycCount;

  trig_window_integrator #(.TRIGS(TRIGS), .DW(DW)) uut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0, edges = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference state
  bit s1, s2, prevT, en, rs, fs, stEv, spEv;
  int disc, vc, cc, m;
  longint acc, sum, expData;
  bit expValid;

  always @(posedge clk) begin
    edges++;
    if (!rstN) begin
      s1 = 0; s2 = 0; prevT = 0; en = 0; disc = 0; vc = 0; cc = 0;
      acc = 0; expValid = 0; expData = 0;
    end else begin
      m = trigMode;
      rs = s2 && !prevT;
      fs = !s2 && prevT;
      stEv = (m == 2 && rs) || (m == 1 && fs);
      spEv = (m == 2 && fs) || (m == 1 && rs);
      expValid = 0;
      if (m == 0) begin
        en = 0; disc = 0; vc = 0; cc = 0;
        if (resValid) begin expValid = 1; expData = longint'($signed(resData)); end
      end else if (!en) begin
        if (m == 3 || stEv) begin en = 1; disc = discardNum; vc = 0; cc = 0; end
      end else if (m != 3 && extWindow && spEv) begin
        en = 0; vc = 0;
      end else if (resValid) begin
        if (disc > 0) disc--;
        else begin
          sum = (vc == 0) ? longint'($signed(resData)) : acc + longint'($signed(resData));
          acc = sum;
          if (vc == integNum) begin
            expValid = 1; expData = sum; vc = 0;
            if (m != 3 && !extWindow && cc == repeatNum) en = 0;
            cc = (m == 3) ? 0 : (cc + 1) % 8;
          end else vc++;
        end
      end
      prevT = s2; s2 = s1; s1 = trigVec[trigSel];
    end
  end

  task automatic chk(string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (edges > 0 && !done) begin
      chk("intValid", intValid, expValid);
      chk("intData", longint'($signed(intData)), expData);
      chk("intEnable", intEnable, en);
      chk("valCount", valCount, vc);
      chk("cycCount", cycCount, cc);
    end
  end

  task automatic run(int n, int dens);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      resValid = (($urandom % 100) < dens);
      resData  = DW'($urandom % 2001) - DW'(1000);
    end
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    run(3, 50);
    rstN = 1;
    run(3, 0);
    // R2: pass-through
    tag = "R2";
    trigMode = 2'b00;
    run(20, 70);
    // R3, R4, R5, R6, R10: rising start, counted window
    tag = "R3/R4/R5/R6";
    trigMode = 2'b10; extWindow = 0; discardNum = 2; integNum = 3; repeatNum = 1;
    trigSel = 0;
    run(10, 80);
    trigVec[0] = 1;
    run(8, 90);
    tag = "R10";
    trigVec[0] = 0; run(4, 90);
    trigVec[0] = 1; run(30, 90);
    tag = "R6";
    run(20, 60);
    // R7, R9: falling start, edge-ended window on line 2
    tag = "R7/R9";
    trigMode = 2'b01; extWindow = 1; discardNum = 0; integNum = 1; trigSel = 2;
    trigVec[2] = 1; run(6, 80);
    trigVec[0] = 0; run(6, 80);
    trigVec[2] = 0; run(25, 80);
    trigVec[0] = 1; run(6, 80);
    trigVec[2] = 1; run(10, 80);
    // R3 with falling start, one value per sum
    tag = "R3/R5";
    integNum = 0;
    trigVec[2] = 0; run(12, 100);
    trigVec[2] = 1; run(6, 100);
    // R8: permanent window
    tag = "R8";
    trigMode = 2'b11; extWindow = 0; discardNum = 3; integNum = 4; repeatNum = 0;
    run(10, 0);
    run(50, 75);
    trigVec[2] = 0; run(10, 75);
    // back to pass-through
    tag = "R2";
    trigMode = 2'b00;
    run(12, 60);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule